// File: doc/BRIEF.md
# SMBus Host Transaction Sequencer

This block is a byte-wide, register-mapped SMBus host. Software fills in a target address, a command byte and up to two data bytes, or loads a block buffer through a single data port. It then writes a start bit into the control register. The block expands the selected protocol into a series of byte-level bus operations and hands them, one at a time, to a downstream byte-level I2C engine. The operations are start with direction, send byte, receive byte, NACK and stop.

Each operation is held on the engine interface until the engine returns a one-cycle done pulse. For start operations the engine also reports whether the address was acknowledged. Received bytes are written back into the data registers or into the block buffer. Software polls a status register for busy, completion and error.

Top module: `smb_host_seq`

## Requirements
- R1: After reset every register reads zero, status reads 0x00 and `op_valid` is low.
- R2: Register offsets are status=0, control=2, command=3, target=4, data0=5, data1=6 and block port=7. Accesses are one byte wide. A control read returns only bits 4:0, and offset 1 reads 0x00.
- R3: Control bits 4:2 carry the protocol code: 0 quick, 1 byte, 2 byte-data, 3 word-data, 5 block. A control write with bit 6 set and any other code sets status bit 2 and issues no operation.
- R4: Operation codes on `op_kind` are 0 start-write, 1 start-read, 2 send, 3 receive, 4 NACK and 5 stop. Quick issues a start in the direction given by target bit 0 (1 = read) and then a stop. `op_addr` carries target bits 7:1.
- R5: Byte protocol: a write issues start-write, send(command), stop. A read issues start-read, receive, NACK, stop and places the received byte in data0.
- R6: Byte-data: a write issues start-write, send(command), send(data0), stop. A read issues start-write, send(command), start-read, receive into data0, NACK, stop.
- R7: Word-data moves the low byte first: data0 then data1 on writes. On reads the first received byte goes to data0 and the second to data1, followed by NACK and stop.
- R8: A block write sends the command, then a length byte equal to data0 capped at 32, then that many buffer bytes from buffer entry 0 upward, then stop.
- R9: A block read issues start-write, send(command) and start-read, then receives a length byte. Any length above 32 counts as 0. The block receives that many further bytes into buffer entries 0 upward, stores the effective length in data0, then issues NACK and stop.
- R10: The block port reads or writes the 32-entry buffer at an index that post-increments and wraps from 31 to 0. A write to status, or a read of control, resets the index to 0.
- R11: Status bit 0 is high while a transaction runs, from the cycle after the launching write. Status bit 1 is set when a transaction finishes without error. A status write clears bits 1 and 2.
- R12: If the engine reports a NAK on a start, status bit 2 is set, bit 1 stays clear, and the next operation is a stop.
- R13: `op_valid` and `op_kind` hold steady until `eng_done`. A new operation appears only in the cycle after a done pulse, so each operation completes exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (drives read side effects) |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the offset on `reg_addr` |
| op_valid | output | 1 | An operation is presented to the engine |
| op_kind | output | 3 | Operation code (see R4) |
| op_addr | output | 7 | Target address for start operations |
| op_wdata | output | 8 | Byte to send for send operations |
| eng_done | input | 1 | One-cycle completion pulse from the engine |
| eng_nak | input | 1 | With `eng_done` on a start: address not acknowledged |
| eng_rdata | input | 8 | With `eng_done` on a receive: received byte |

## Verification
The bench builds the block with its default buffer depth of 32. At that depth the length cap can be hit exactly: a block write with data0 of 40 must send 32, and a block read announcing 33 must collapse to 0. The same depth lets a 33rd port write land on entry 0 and show the index wrap. The engine model stalls each operation for two cycles, so the hold-until-done rule is exercised on every step. The model NAKs any address other than its own, which reaches the error path.

// File: rtl/smb_host_pkg.sv
package smb_host_pkg;

   typedef enum logic [2:0] {
      OP_START_WR = 3'd0,
      OP_START_RD = 3'd1,
      OP_SEND     = 3'd2,
      OP_RECV     = 3'd3,
      OP_NACK     = 3'd4,
      OP_STOP     = 3'd5
   } smb_op_e;

   typedef enum logic [1:0] {
      DST_D0  = 2'd0,
      DST_D1  = 2'd1,
      DST_BUF = 2'd2
   } rx_dst_e;

   localparam logic [2:0] PR_QUICK = 3'd0;
   localparam logic [2:0] PR_BYTE  = 3'd1;
   localparam logic [2:0] PR_BDATA = 3'd2;
   localparam logic [2:0] PR_WORD  = 3'd3;
   localparam logic [2:0] PR_BLOCK = 3'd5;

   localparam logic [2:0] RG_STAT = 3'd0;
   localparam logic [2:0] RG_CTL  = 3'd2;
   localparam logic [2:0] RG_CMD  = 3'd3;
   localparam logic [2:0] RG_TGT  = 3'd4;
   localparam logic [2:0] RG_D0   = 3'd5;
   localparam logic [2:0] RG_D1   = 3'd6;
   localparam logic [2:0] RG_BLK  = 3'd7;

   function automatic logic proto_ok(input logic [2:0] p);
      return (p == PR_QUICK) || (p == PR_BYTE) || (p == PR_BDATA) ||
             (p == PR_WORD)  || (p == PR_BLOCK);
   endfunction

endpackage

// File: rtl/smb_blk_buf.sv
module smb_blk_buf #(
   parameter int DEPTH = 32,
   parameter int DW    = 8,
   parameter int IW    = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          h_clr,
   input  logic          h_adv,
   input  logic          h_we,
   input  logic [DW-1:0] h_wdata,
   output logic [DW-1:0] h_rdata,
   input  logic          s_we,
   input  logic [IW-1:0] s_addr,
   input  logic [DW-1:0] s_wdata,
   output logic [DW-1:0] s_rdata
);

   logic [DW-1:0] mem [DEPTH];
   logic [IW-1:0] idx_q;
   logic [IW-1:0] idx_inc;

   generate
      if ((1 << IW) == DEPTH) begin : g_pow2_wrap
         assign idx_inc = idx_q + IW'(1);
      end else begin : g_cmp_wrap
         assign idx_inc = (idx_q == IW'(DEPTH - 1)) ? '0 : idx_q + IW'(1);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     idx_q <= '0;
      else if (h_clr) idx_q <= '0;
      else if (h_adv) idx_q <= idx_inc;
   end

   always_ff @(posedge clk) begin
      if (h_we) mem[idx_q]  <= h_wdata;
      if (s_we) mem[s_addr] <= s_wdata;
   end

   assign h_rdata = mem[idx_q];
   assign s_rdata = mem[s_addr];

   assert_idx_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (h_adv && !h_clr && idx_q == IW'(DEPTH - 1)) |=> (idx_q == '0));

   assert_idx_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      h_clr |=> (idx_q == '0));

endmodule

// File: rtl/smb_seq_fsm.sv
module smb_seq_fsm
   import smb_host_pkg::*;
#(
   parameter int BLK_MAX = 32,
   parameter int IW      = $clog2(BLK_MAX)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          launch,
   input  logic [2:0]    proto,
   input  logic          dir_rd,
   input  logic [6:0]    tgt,
   input  logic [7:0]    cmd,
   input  logic [7:0]    d0,
   input  logic [7:0]    d1,
   input  logic [7:0]    buf_rdata,
   output logic [IW-1:0] buf_addr,
   output logic          busy,
   output logic          fin_ok,
   output logic          nak_err,
   output logic          rx_we,
   output rx_dst_e       rx_dst,
   output logic [7:0]    rx_byte,
   output logic          op_valid,
   output smb_op_e       op_kind,
   output logic [6:0]    op_addr,
   output logic [7:0]    op_wdata,
   input  logic          eng_done,
   input  logic          eng_nak,
   input  logic [7:0]    eng_rdata
);

   localparam int LW = $clog2(BLK_MAX + 2);

   typedef enum logic [2:0] {
      S_IDLE, S_START1, S_CMD, S_START2, S_TX, S_RX, S_NACK, S_STOP
   } st_e;

   st_e           st_q;
   logic [2:0]    pr_q;
   logic          rd_q;
   logic          nak_q;
   logic [LW-1:0] cnt_q;
   logic [LW-1:0] rxn_q;
   logic [LW-1:0] tx_len;
   logic [LW-1:0] tx_total;
   logic [LW-1:0] rx_len;
   logic          first_rd;

   // write length saturates, read length above the cap collapses to zero
   assign tx_len = (d0 > 8'(BLK_MAX)) ? LW'(BLK_MAX) : d0[LW-1:0];
   assign rx_len = (eng_rdata > 8'(BLK_MAX)) ? '0 : eng_rdata[LW-1:0];

   always_comb begin
      case (pr_q)
         PR_BDATA: tx_total = LW'(1);
         PR_WORD:  tx_total = LW'(2);
         default:  tx_total = tx_len + LW'(1);
      endcase
   end

   assign first_rd = (pr_q == PR_QUICK) ? rd_q : ((pr_q == PR_BYTE) && rd_q);
   assign buf_addr = IW'(cnt_q - LW'(1));
   assign busy     = (st_q != S_IDLE);
   assign op_valid = busy;
   assign op_addr  = tgt;

   always_comb begin
      op_wdata = cmd;
      case (st_q)
         S_START1: op_kind = first_rd ? OP_START_RD : OP_START_WR;
         S_CMD:    op_kind = OP_SEND;
         S_START2: op_kind = OP_START_RD;
         S_TX: begin
            op_kind = OP_SEND;
            if (pr_q == PR_BLOCK)     op_wdata = (cnt_q == '0) ? 8'(tx_len) : buf_rdata;
            else if (pr_q == PR_WORD) op_wdata = (cnt_q == '0) ? d0 : d1;
            else                      op_wdata = d0;
         end
         S_RX:     op_kind = OP_RECV;
         S_NACK:   op_kind = OP_NACK;
         default:  op_kind = OP_STOP;
      endcase
   end

   always_comb begin
      rx_we   = (st_q == S_RX) && eng_done;
      rx_byte = eng_rdata;
      rx_dst  = DST_D0;
      if (pr_q == PR_BLOCK) begin
         if (cnt_q == '0) rx_byte = 8'(rx_len);
         else             rx_dst  = DST_BUF;
      end else if (pr_q == PR_WORD && cnt_q != '0) begin
         rx_dst = DST_D1;
      end
   end

   assign fin_ok  = (st_q == S_STOP) && eng_done && !nak_q;
   assign nak_err = ((st_q == S_START1) || (st_q == S_START2)) && eng_done && eng_nak;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= S_IDLE;
         pr_q  <= PR_QUICK;
         rd_q  <= 1'b0;
         nak_q <= 1'b0;
         cnt_q <= '0;
         rxn_q <= '0;
      end else if (st_q == S_IDLE) begin
         if (launch) begin
            st_q  <= S_START1;
            pr_q  <= proto;
            rd_q  <= dir_rd;
            nak_q <= 1'b0;
            cnt_q <= '0;
         end
      end else if (eng_done) begin
         case (st_q)
            S_START1: begin
               if (eng_nak) begin
                  nak_q <= 1'b1;
                  st_q  <= S_STOP;
               end else if (pr_q == PR_QUICK) begin
                  st_q <= S_STOP;
               end else if (pr_q == PR_BYTE && rd_q) begin
                  st_q  <= S_RX;
                  cnt_q <= '0;
                  rxn_q <= LW'(1);
               end else begin
                  st_q <= S_CMD;
               end
            end
            S_CMD: begin
               if (pr_q == PR_BYTE) st_q <= S_STOP;
               else if (rd_q)       st_q <= S_START2;
               else begin
                  st_q  <= S_TX;
                  cnt_q <= '0;
               end
            end
            S_START2: begin
               if (eng_nak) begin
                  nak_q <= 1'b1;
                  st_q  <= S_STOP;
               end else begin
                  st_q  <= S_RX;
                  cnt_q <= '0;
                  rxn_q <= (pr_q == PR_WORD) ? LW'(2) : LW'(1);
               end
            end
            S_TX: begin
               if (cnt_q + LW'(1) == tx_total) st_q <= S_STOP;
               else                            cnt_q <= cnt_q + LW'(1);
            end
            S_RX: begin
               if (pr_q == PR_BLOCK && cnt_q == '0) begin
                  if (rx_len == '0) st_q <= S_NACK;
                  else begin
                     rxn_q <= rx_len + LW'(1);
                     cnt_q <= LW'(1);
                  end
               end else if (cnt_q + LW'(1) == rxn_q) begin
                  st_q <= S_NACK;
               end else begin
                  cnt_q <= cnt_q + LW'(1);
               end
            end
            S_NACK:  st_q <= S_STOP;
            default: st_q <= S_IDLE;
         endcase
      end
   end

   assert_op_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && !eng_done) |=> (op_valid && $stable(op_kind) && $stable(op_wdata)));

   assert_nak_stop_R12: assert property (@(posedge clk) disable iff (!rst_n)
      nak_err |=> (op_valid && op_kind == OP_STOP));

   assert_len_cap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == S_TX) |-> (cnt_q <= LW'(BLK_MAX)));

endmodule

// File: rtl/smb_host_seq.sv
module smb_host_seq
   import smb_host_pkg::*;
#(
   parameter int BLK_MAX = 32
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       reg_wr,
   input  logic       reg_rd,
   input  logic [2:0] reg_addr,
   input  logic [7:0] reg_wdata,
   output logic [7:0] reg_rdata,
   output logic       op_valid,
   output logic [2:0] op_kind,
   output logic [6:0] op_addr,
   output logic [7:0] op_wdata,
   input  logic       eng_done,
   input  logic       eng_nak,
   input  logic [7:0] eng_rdata
);

   localparam int IW = $clog2(BLK_MAX);

   generate
      if (BLK_MAX < 2 || BLK_MAX > 127) begin : g_bad_depth
         $error("BLK_MAX must lie in 2..127");
      end
   endgenerate

   logic [4:0]    ctl_q;
   logic [7:0]    cmd_q, tgt_q, d0_q, d1_q;
   logic          done_q, err_q;
   logic          busy, fin_ok, nak_err, rx_we;
   rx_dst_e       rx_dst;
   logic [7:0]    rx_byte, buf_h_rdata, buf_s_rdata;
   logic [IW-1:0] buf_s_addr;
   smb_op_e       kind;
   logic          ctl_go, launch, bad_go;

   assign ctl_go = reg_wr && (reg_addr == RG_CTL) && reg_wdata[6] && !busy;
   assign launch = ctl_go && proto_ok(reg_wdata[4:2]);
   assign bad_go = ctl_go && !proto_ok(reg_wdata[4:2]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q  <= '0;
         cmd_q  <= '0;
         tgt_q  <= '0;
         d0_q   <= '0;
         d1_q   <= '0;
         done_q <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         if (reg_wr) begin
            case (reg_addr)
               RG_STAT: begin
                  done_q <= 1'b0;
                  err_q  <= 1'b0;
               end
               RG_CTL:  ctl_q <= reg_wdata[4:0];
               RG_CMD:  cmd_q <= reg_wdata;
               RG_TGT:  tgt_q <= reg_wdata;
               RG_D0:   d0_q  <= reg_wdata;
               RG_D1:   d1_q  <= reg_wdata;
               default: ;
            endcase
         end
         if (bad_go || nak_err) err_q  <= 1'b1;
         if (fin_ok)            done_q <= 1'b1;
         if (rx_we && rx_dst == DST_D0) d0_q <= rx_byte;
         if (rx_we && rx_dst == DST_D1) d1_q <= rx_byte;
      end
   end

   always_comb begin
      case (reg_addr)
         RG_STAT: reg_rdata = {5'b0, err_q, done_q, busy};
         RG_CTL:  reg_rdata = {3'b0, ctl_q};
         RG_CMD:  reg_rdata = cmd_q;
         RG_TGT:  reg_rdata = tgt_q;
         RG_D0:   reg_rdata = d0_q;
         RG_D1:   reg_rdata = d1_q;
         RG_BLK:  reg_rdata = buf_h_rdata;
         default: reg_rdata = 8'h00;
      endcase
   end

   smb_blk_buf #(.DEPTH(BLK_MAX), .DW(8), .IW(IW)) u_buf (
      .clk     (clk),
      .rst_n   (rst_n),
      .h_clr   ((reg_wr && reg_addr == RG_STAT) || (reg_rd && reg_addr == RG_CTL)),
      .h_adv   ((reg_wr || reg_rd) && reg_addr == RG_BLK),
      .h_we    (reg_wr && reg_addr == RG_BLK),
      .h_wdata (reg_wdata),
      .h_rdata (buf_h_rdata),
      .s_we    (rx_we && rx_dst == DST_BUF),
      .s_addr  (buf_s_addr),
      .s_wdata (rx_byte),
      .s_rdata (buf_s_rdata)
   );

   smb_seq_fsm #(.BLK_MAX(BLK_MAX), .IW(IW)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .launch    (launch),
      .proto     (reg_wdata[4:2]),
      .dir_rd    (tgt_q[0]),
      .tgt       (tgt_q[7:1]),
      .cmd       (cmd_q),
      .d0        (d0_q),
      .d1        (d1_q),
      .buf_rdata (buf_s_rdata),
      .buf_addr  (buf_s_addr),
      .busy      (busy),
      .fin_ok    (fin_ok),
      .nak_err   (nak_err),
      .rx_we     (rx_we),
      .rx_dst    (rx_dst),
      .rx_byte   (rx_byte),
      .op_valid  (op_valid),
      .op_kind   (kind),
      .op_addr   (op_addr),
      .op_wdata  (op_wdata),
      .eng_done  (eng_done),
      .eng_nak   (eng_nak),
      .eng_rdata (eng_rdata)
   );

   assign op_kind = kind;

   assert_busy_launch_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(reg_wr && reg_addr == RG_CTL && reg_wdata[6]));

   assert_bad_proto_R3: assert property (@(posedge clk) disable iff (!rst_n)
      bad_go |=> (!busy && err_q && !op_valid));

   assert_nak_no_done_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (nak_err && !(reg_wr && reg_addr == RG_STAT)) |=> err_q);

endmodule

// File: tb/smb_host_seq_test.sv
module smb_host_seq_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr = 1'b0, reg_rd = 1'b0;
   logic [2:0] reg_addr = 3'd0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic       op_valid;
   logic [2:0] op_kind;
   logic [6:0] op_addr;
   logic [7:0] op_wdata;
   logic       eng_done = 1'b0, eng_nak = 1'b0;
   logic [7:0] eng_rdata = 8'h00;

   int nchk = 0, nfail = 0;
   bit finished = 0;

   // engine model state
   logic [2:0] lk [80];
   logic [7:0] lw [80];
   int         nlog = 0;
   logic [7:0] rx_src [64];
   int         rx_ptr = 0;
   logic [6:0] model_tgt = 7'h2A;
   // expected operation list
   logic [2:0] ek [80];
   logic [7:0] ew [80];
   int         ne = 0;

   always #2 clk = ~clk;

   smb_host_seq uut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .op_valid(op_valid), .op_kind(op_kind), .op_addr(op_addr),
      .op_wdata(op_wdata), .eng_done(eng_done), .eng_nak(eng_nak),
      .eng_rdata(eng_rdata)
   );

   // byte engine model: completes each operation after a two-cycle stall
   initial begin
      int wcnt;
      wcnt = 0;
      forever begin
         @(negedge clk);
         if (eng_done) begin
            eng_done = 1'b0;
            eng_nak  = 1'b0;
         end else if (op_valid) begin
            wcnt++;
            if (wcnt == 2) begin
               wcnt = 0;
               if (nlog < 80) begin
                  lk[nlog] = op_kind;
                  lw[nlog] = (op_kind <= 3'd1) ? {1'b0, op_addr} : op_wdata;
                  nlog++;
               end
               eng_nak = (op_kind <= 3'd1) && (op_addr != model_tgt);
               if (op_kind == 3'd3) begin
                  eng_rdata = rx_src[rx_ptr];
                  rx_ptr++;
               end
               eng_done = 1'b1;
            end
         end
      end
   end

   task automatic check(input string req, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] v);
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = a;
      #1 v = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic ex(input logic [2:0] k, input logic [7:0] w);
      ek[ne] = k; ew[ne] = w; ne++;
   endtask

   task automatic wait_idle();
      logic [7:0] s;
      for (int i = 0; i < 500; i++) begin
         rd(3'd0, s);
         if (s[0] == 1'b0) break;
      end
   endtask

   task automatic run(input logic [7:0] ctl);
      logic [7:0] s;
      nlog = 0; rx_ptr = 0;
      wr(3'd2, ctl);
      rd(3'd0, s);
      if (ctl != 8'h50 && ctl != 8'h5C) check("R11 busy after launch", s[0], 1);
      wait_idle();
   endtask

   task automatic cmp_log(input string req);
      check({req, " op count (R13)"}, nlog, ne);
      for (int i = 0; i < ne && i < nlog; i++) begin
         check({req, " op kind"}, lk[i], ek[i]);
         if (ek[i] <= 3'd2) check({req, " op byte"}, lw[i], ew[i]);
      end
   endtask

   task automatic t_reset();
      logic [7:0] v;
      check("R1 op_valid", op_valid, 0);
      rd(3'd0, v); check("R1 status", v, 8'h00);
      rd(3'd2, v); check("R1 control", v, 8'h00);
      rd(3'd5, v); check("R1 data0", v, 8'h00);
   endtask

   task automatic t_regmap();
      logic [7:0] v;
      wr(3'd3, 8'hA5); wr(3'd4, 8'hB4); wr(3'd5, 8'h11); wr(3'd6, 8'h22);
      wr(3'd2, 8'h9F);
      rd(3'd3, v); check("R2 command", v, 8'hA5);
      rd(3'd4, v); check("R2 target", v, 8'hB4);
      rd(3'd5, v); check("R2 data0", v, 8'h11);
      rd(3'd6, v); check("R2 data1", v, 8'h22);
      rd(3'd2, v); check("R2 control low bits", v, 8'h1F);
      rd(3'd1, v); check("R2 offset1", v, 8'h00);
      check("R2 no launch", op_valid, 0);
   endtask

   task automatic t_bad_proto();
      logic [7:0] v;
      ne = 0;
      run(8'h50);
      rd(3'd0, v); check("R3 code4 error", v, 8'h04);
      cmp_log("R3 code4");
      wr(3'd0, 8'h00);
      run(8'h5C);
      rd(3'd0, v); check("R3 code7 error", v, 8'h04);
      cmp_log("R3 code7");
      wr(3'd0, 8'h00);
      rd(3'd0, v); check("R11 status clear", v, 8'h00);
   endtask

   task automatic t_quick();
      logic [7:0] v;
      wr(3'd4, 8'h54);
      ne = 0; ex(3'd0, 8'h2A); ex(3'd5, 0);
      run(8'h40);
      cmp_log("R4 quick write");
      rd(3'd0, v); check("R11 done flag", v, 8'h02);
      wr(3'd0, 0); wr(3'd4, 8'h55);
      ne = 0; ex(3'd1, 8'h2A); ex(3'd5, 0);
      run(8'h40);
      cmp_log("R4 quick read");
      wr(3'd0, 0);
   endtask

   task automatic t_byte();
      logic [7:0] v;
      wr(3'd4, 8'h54); wr(3'd3, 8'h3C);
      ne = 0; ex(3'd0, 8'h2A); ex(3'd2, 8'h3C); ex(3'd5, 0);
      run(8'h44);
      cmp_log("R5 send byte");
      wr(3'd0, 0); wr(3'd4, 8'h55);
      rx_src[0] = 8'h9E;
      ne = 0; ex(3'd1, 8'h2A); ex(3'd3, 0); ex(3'd4, 0); ex(3'd5, 0);
      run(8'h44);
      cmp_log("R5 receive byte");
      rd(3'd5, v); check("R5 received to data0", v, 8'h9E);
      wr(3'd0, 0);
   endtask

   task automatic t_bdata();
      logic [7:0] v;
      wr(3'd4, 8'h54); wr(3'd3, 8'h10); wr(3'd5, 8'h77);
      ne = 0; ex(3'd0, 8'h2A); ex(3'd2, 8'h10); ex(3'd2, 8'h77); ex(3'd5, 0);
      run(8'h48);
      cmp_log("R6 write byte-data");
      wr(3'd0, 0); wr(3'd4, 8'h55);
      rx_src[0] = 8'h6B;
      ne = 0; ex(3'd0, 8'h2A); ex(3'd2, 8'h10); ex(3'd1, 8'h2A);
      ex(3'd3, 0); ex(3'd4, 0); ex(3'd5, 0);
      run(8'h48);
      cmp_log("R6 read byte-data");
      rd(3'd5, v); check("R6 data0", v, 8'h6B);
      wr(3'd0, 0);
   endtask

   task automatic t_word();
      logic [7:0] v;
      wr(3'd4, 8'h54); wr(3'd3, 8'h21); wr(3'd5, 8'h34); wr(3'd6, 8'h12);
      ne = 0; ex(3'd0, 8'h2A); ex(3'd2, 8'h21); ex(3'd2, 8'h34); ex(3'd2, 8'h12); ex(3'd5, 0);
      run(8'h4C);
      cmp_log("R7 word write low first");
      wr(3'd0, 0); wr(3'd4, 8'h55);
      rx_src[0] = 8'hCD; rx_src[1] = 8'hAB;
      ne = 0; ex(3'd0, 8'h2A); ex(3'd2, 8'h21); ex(3'd1, 8'h2A);
      ex(3'd3, 0); ex(3'd3, 0); ex(3'd4, 0); ex(3'd5, 0);
      run(8'h4C);
      cmp_log("R7 word read");
      rd(3'd5, v); check("R7 low byte in data0", v, 8'hCD);
      rd(3'd6, v); check("R7 high byte in data1", v, 8'hAB);
      wr(3'd0, 0);
   endtask

   task automatic t_block_wr();
      wr(3'd0, 0);
      wr(3'd7, 8'h01); wr(3'd7, 8'h02); wr(3'd7, 8'h03);
      wr(3'd4, 8'h54); wr(3'd3, 8'h40); wr(3'd5, 8'd3);
      ne = 0; ex(3'd0, 8'h2A); ex(3'd2, 8'h40); ex(3'd2, 8'd3);
      ex(3'd2, 8'h01); ex(3'd2, 8'h02); ex(3'd2, 8'h03); ex(3'd5, 0);
      run(8'h54);
      cmp_log("R8 block write 3");
      wr(3'd0, 0);
      for (int i = 0; i < 32; i++) wr(3'd7, 8'(i * 3 + 1));
      wr(3'd5, 8'd40);
      ne = 0; ex(3'd0, 8'h2A); ex(3'd2, 8'h40); ex(3'd2, 8'd32);
      for (int i = 0; i < 32; i++) ex(3'd2, 8'(i * 3 + 1));
      ex(3'd5, 0);
      run(8'h54);
      cmp_log("R8 block write capped");
      wr(3'd0, 0);
   endtask

   task automatic t_block_rd();
      logic [7:0] v;
      wr(3'd4, 8'h55); wr(3'd3, 8'h41);
      rx_src[0] = 8'd4;
      for (int i = 0; i < 4; i++) rx_src[i + 1] = 8'hE0 + 8'(i);
      ne = 0; ex(3'd0, 8'h2A); ex(3'd2, 8'h41); ex(3'd1, 8'h2A);
      for (int i = 0; i < 5; i++) ex(3'd3, 0);
      ex(3'd4, 0); ex(3'd5, 0);
      run(8'h54);
      cmp_log("R9 block read 4");
      rd(3'd5, v); check("R9 length in data0", v, 8'd4);
      rd(3'd2, v);
      for (int i = 0; i < 4; i++) begin
         rd(3'd7, v); check("R9 buffer byte", v, 8'hE0 + i);
      end
      wr(3'd0, 0);
      rx_src[0] = 8'd33;
      ne = 0; ex(3'd0, 8'h2A); ex(3'd2, 8'h41); ex(3'd1, 8'h2A);
      ex(3'd3, 0); ex(3'd4, 0); ex(3'd5, 0);
      run(8'h54);
      cmp_log("R9 over-length read");
      rd(3'd5, v); check("R9 over-length gives 0", v, 8'd0);
      wr(3'd0, 0);
   endtask

   task automatic t_index();
      logic [7:0] v;
      wr(3'd0, 0);
      for (int i = 0; i < 32; i++) wr(3'd7, 8'h80 + 8'(i));
      wr(3'd7, 8'hFF);
      rd(3'd2, v);
      rd(3'd7, v); check("R10 wrap 31 to 0", v, 8'hFF);
      rd(3'd7, v); check("R10 post increment", v, 8'h81);
      wr(3'd0, 0);
      rd(3'd7, v); check("R10 status write resets index", v, 8'hFF);
   endtask

   task automatic t_nak();
      logic [7:0] v;
      wr(3'd0, 0);
      wr(3'd4, 8'h60); wr(3'd3, 8'h10);
      ne = 0; ex(3'd0, 8'h30); ex(3'd5, 0);
      run(8'h48);
      cmp_log("R12 nak then stop");
      rd(3'd0, v); check("R12 error not done", v, 8'h04);
      wr(3'd0, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_regmap();
      t_bad_proto();
      t_quick();
      t_byte();
      t_bdata();
      t_word();
      t_block_wr();
      t_block_rd();
      t_index();
      t_nak();
      if (!finished) begin
         finished = 1;
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   end

   initial begin
      #(4 * 150000);
      if (!finished) begin
         finished = 1;
         nchk++; nfail++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   end

endmodule